// File: doc/BRIEF.md
# DQS Delay Window Training Sequencer

This block calibrates the strobe timing of a DDR memory interface without software. It steps through a grid of settings. The outer dimension is a write-strobe shift. The inner dimension is a delay-line value, which is applied to every byte lane at the same time. For each setting the block stops the memory core and programs the new values. It then restarts the core, waits for the delay line to lock and for the core to report that initialization is complete, and lets the interface settle. After that it writes a fixed data pattern and reads every word back several times through a plain single-word memory port.

For each shift value the sequencer tracks the longest unbroken run of passing delay values. When the grid is exhausted it programs the best shift and the midpoint of the best run, restarts the core a final time and raises `done_o`. A status wait that never succeeds stops the run with `err_o` and reports the setting in use. A grid in which nothing passes ends in `done_o` with `no_window_o` set.

Top module: `dqs_window_trainer`

## Requirements
- R1: After reset the block is idle: `done_o`, `err_o`, `no_window_o`, `core_run_o`, `mem_we_o` and `mem_re_o` are 0, every lane delay is 0 and `wr_shift_o` equals SHIFT_FIRST. A `start_i` pulse while idle clears `done_o`, `err_o` and `no_window_o` and begins a run. A `start_i` pulse during a run has no effect.
- R2: The write shift steps from SHIFT_FIRST up to SHIFT_LAST inclusive. `out_shift_o` always equals `wr_shift_o` + OUT_OFFSET (32), truncated to SHIFT_W bits.
- R3: Within each shift the delay steps from DELAY_FIRST up to DELAY_LAST inclusive. All LANES fields of `lane_delay_o` carry the same value, with lane i at bits [i*DLY_W +: DLY_W].
- R4: Shift and delay outputs change only while `core_run_o` is low. After programming, `core_run_o` rises and the block waits for `lock_i` and then for `init_done_i`.
- R5: A status wait fails after POLL_LIMIT cycles in which the awaited input is sampled low. The run then stops with `err_o`=1 and `done_o`=0, with `err_shift_o`/`err_delay_o` holding the setting in use, and `core_run_o` drops.
- R6: After `init_done_i` is seen, SETTLE_CYCLES cycles pass before the first memory access. A memory access happens only while `core_run_o` is high.
- R7: The test writes PAT_WORDS words to addresses 0 upward. Word i is chosen by group g = i[5:4] and selector s = i[1]^i[3]. The values are: g0 gives 0x00000000 (s=0) or 0xFFFFFFFF (s=1); g1 gives 0xAAAAAAAA or 0x55555555; g2 gives 0xA5A5A5A5 or 0x5A5A5A5A; g3 gives 0xAA55AA55 or 0x55AA55AA. Write and read are never asserted together.
- R8: Each word is then read READS times. `mem_rdata_i` is valid one cycle after `mem_re_o`. A single mismatching read fails the setting.
- R9: A failing setting sets the run length to zero. The run length is also cleared at the start of each shift, so runs never span two shifts.
- R10: When a run's length is at least the best so far, the best shift, the run start and the run end are taken from it. Among equally long runs, the later one wins.
- R11: At the end of the grid the block programs the best shift, that shift + 32, and the delay (start+end)/2 truncated. It then restarts the core, waits for lock and init, and raises `done_o` with `core_run_o` left high.
- R12: If no setting passed, the block programs delay 0 and shift SHIFT_FIRST, and `done_o` rises with `no_window_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a training run (pulse) |
| lock_i | input | 1 | Delay line locked |
| init_done_i | input | 1 | Memory core initialization complete |
| core_run_o | output | 1 | Memory core start control |
| wr_shift_o | output | SHIFT_W | Write-strobe shift |
| out_shift_o | output | SHIFT_W | Output-strobe shift |
| lane_delay_o | output | LANES*DLY_W | Per-lane delay-line values |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after read |
| done_o | output | 1 | Training finished |
| no_window_o | output | 1 | No passing setting was found |
| err_o | output | 1 | A status wait timed out |
| err_shift_o | output | SHIFT_W | Shift in use when the timeout occurred |
| err_delay_o | output | DLY_W | Delay in use when the timeout occurred |

## Verification
Several properties are checked on every cycle: the fixed offset between the two shifts, equal lane fields, configuration held steady while the core runs, memory access only with the core running and initialized, exclusive write and read, `done_o` and `err_o` never both high, and the zero delay that goes with `no_window_o`. Only the bench scenarios can show the rest. These include picking the right window from a pass map with a tie, the midpoint truncation, a run that must not carry across shifts, and a lone pass at the last grid point. They also cover the all-fail result, the timeout cycle count with the reported setting, the settle gap, the pattern contents and the exact number of writes and reads.

// File: rtl/dqs_train_pkg.sv
package dqs_train_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_ARM, ST_WAIT, ST_TEST, ST_EVAL,
    ST_FIN_PROG, ST_FIN_ARM, ST_FIN_WAIT
  } seq_state_e;

  // Training word for index idx: group from bits 5:4, polarity from bit1 ^ bit3.
  function automatic logic [WORD_W-1:0] pat_word(input logic [31:0] idx);
    logic sel;
    sel = idx[1] ^ idx[3];
    case (idx[5:4])
      2'd0:    pat_word = sel ? 32'hFFFF_FFFF : 32'h0000_0000;
      2'd1:    pat_word = sel ? 32'h5555_5555 : 32'hAAAA_AAAA;
      2'd2:    pat_word = sel ? 32'h5A5A_5A5A : 32'hA5A5_A5A5;
      default: pat_word = sel ? 32'h55AA_55AA : 32'hAA55_AA55;
    endcase
  endfunction

endpackage

// File: rtl/dqs_status_waiter.sv
module dqs_status_waiter #(
  parameter int POLL_LIMIT    = 65535,
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic lock_i,
  input  logic init_i,
  output logic ok,
  output logic timeout
);
  localparam int POLL_W   = $clog2(POLL_LIMIT + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [1:0] {W_IDLE, W_LOCK, W_INIT, W_SETTLE} wait_state_e;

  wait_state_e       wst;
  logic [POLL_W-1:0] polls;
  logic [SETTLE_W-1:0] settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst     <= W_IDLE;
      polls   <= '0;
      settle  <= '0;
      ok      <= 1'b0;
      timeout <= 1'b0;
    end else begin
      ok      <= 1'b0;
      timeout <= 1'b0;
      case (wst)
        W_IDLE: if (go) begin
          wst   <= W_LOCK;
          polls <= '0;
        end
        W_LOCK: begin
          if (lock_i) begin
            wst   <= W_INIT;
            polls <= '0;
          end else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
            wst     <= W_IDLE;
            timeout <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        W_INIT: begin
          if (init_i) begin
            wst    <= W_SETTLE;
            settle <= '0;
          end else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
            wst     <= W_IDLE;
            timeout <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        default: begin
          if (settle == SETTLE_W'(SETTLE_CYCLES - 1)) begin
            wst <= W_IDLE;
            ok  <= 1'b1;
          end else begin
            settle <= settle + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dqs_pattern_tester.sv
module dqs_pattern_tester
  import dqs_train_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PAT_WORDS = 64,
  parameter int READS     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic              pass
);
  localparam int REP_W = $clog2(READS + 1);

  typedef enum logic [1:0] {T_IDLE, T_WRITE, T_READ, T_DRAIN} test_state_e;

  test_state_e       tst;
  logic [ADDR_W-1:0] addr;
  logic [REP_W-1:0]  rep;
  logic              drain_step;
  logic [WORD_W-1:0] exp_q;
  logic              chk_vld;
  logic [WORD_W-1:0] chk_exp;
  logic              fail_q;
  logic              miss;

  assign miss = chk_vld && (mem_rdata != chk_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      tst        <= T_IDLE;
      addr       <= '0;
      rep        <= '0;
      drain_step <= 1'b0;
      exp_q      <= '0;
      chk_vld    <= 1'b0;
      chk_exp    <= '0;
      fail_q     <= 1'b0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
    end else begin
      done    <= 1'b0;
      chk_vld <= mem_re;
      chk_exp <= exp_q;
      if (miss) fail_q <= 1'b1;
      case (tst)
        T_IDLE: if (go) begin
          tst    <= T_WRITE;
          addr   <= '0;
          fail_q <= 1'b0;
        end
        T_WRITE: begin
          mem_we    <= 1'b1;
          mem_addr  <= addr;
          mem_wdata <= pat_word(32'(addr));
          if (addr == ADDR_W'(PAT_WORDS - 1)) begin
            tst  <= T_READ;
            addr <= '0;
            rep  <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        T_READ: begin
          mem_we   <= 1'b0;
          mem_re   <= 1'b1;
          mem_addr <= addr;
          exp_q    <= pat_word(32'(addr));
          if (rep == REP_W'(READS - 1)) begin
            rep <= '0;
            if (addr == ADDR_W'(PAT_WORDS - 1)) begin
              tst        <= T_DRAIN;
              drain_step <= 1'b0;
            end else begin
              addr <= addr + 1'b1;
            end
          end else begin
            rep <= rep + 1'b1;
          end
        end
        default: begin
          mem_re <= 1'b0;
          if (drain_step) begin
            tst  <= T_IDLE;
            done <= 1'b1;
            pass <= !(fail_q || miss);
          end else begin
            drain_step <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dqs_window_tracker.sv
module dqs_window_tracker #(
  parameter int DLY_W   = 7,
  parameter int SHIFT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic               clr_run,
  input  logic               res_valid,
  input  logic               res_pass,
  input  logic [SHIFT_W-1:0] cur_shift,
  input  logic [DLY_W-1:0]   cur_delay,
  output logic               any_pass,
  output logic [SHIFT_W-1:0] best_shift,
  output logic [DLY_W-1:0]   mid_delay
);
  localparam int CNT_W = DLY_W + 1;

  logic [CNT_W-1:0] run_cnt, best_cnt, next_cnt;
  logic [DLY_W-1:0] run_start, next_start, best_start, best_end;
  logic [DLY_W:0]   span_sum;

  always_comb begin
    next_cnt   = run_cnt + 1'b1;
    next_start = (run_cnt == '0) ? cur_delay : run_start;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      run_cnt    <= '0;
      run_start  <= '0;
      best_cnt   <= '0;
      best_shift <= '0;
      best_start <= '0;
      best_end   <= '0;
    end else if (clr_run) begin
      run_cnt <= '0;
    end else if (res_valid) begin
      if (!res_pass) begin
        run_cnt <= '0;
      end else begin
        run_cnt   <= next_cnt;
        run_start <= next_start;
        if (next_cnt >= best_cnt) begin
          best_cnt   <= next_cnt;
          best_shift <= cur_shift;
          best_start <= next_start;
          best_end   <= cur_delay;
        end
      end
    end
  end

  assign span_sum  = {1'b0, best_start} + {1'b0, best_end};
  assign mid_delay = span_sum[DLY_W:1];
  assign any_pass  = (best_cnt != '0);
endmodule

// File: rtl/dqs_window_trainer.sv
module dqs_window_trainer
  import dqs_train_pkg::*;
#(
  parameter int LANES         = 9,
  parameter int DLY_W         = 7,
  parameter int SHIFT_W       = 8,
  parameter int SHIFT_FIRST   = 64,
  parameter int SHIFT_LAST    = 95,
  parameter int OUT_OFFSET    = 32,
  parameter int DELAY_FIRST   = 1,
  parameter int DELAY_LAST    = 63,
  parameter int PAT_WORDS     = 64,
  parameter int ADDR_W        = 6,
  parameter int READS         = 10,
  parameter int POLL_LIMIT    = 65535,
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   lock_i,
  input  logic                   init_done_i,
  output logic                   core_run_o,
  output logic [SHIFT_W-1:0]     wr_shift_o,
  output logic [SHIFT_W-1:0]     out_shift_o,
  output logic [LANES*DLY_W-1:0] lane_delay_o,
  output logic                   mem_we_o,
  output logic                   mem_re_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]      mem_wdata_o,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic                   done_o,
  output logic                   no_window_o,
  output logic                   err_o,
  output logic [SHIFT_W-1:0]     err_shift_o,
  output logic [DLY_W-1:0]       err_delay_o
);
  localparam logic [SHIFT_W-1:0] SH_FIRST = SHIFT_W'(SHIFT_FIRST);
  localparam logic [SHIFT_W-1:0] SH_LAST  = SHIFT_W'(SHIFT_LAST);
  localparam logic [SHIFT_W-1:0] SH_OFF   = SHIFT_W'(OUT_OFFSET);
  localparam logic [DLY_W-1:0]   DL_FIRST = DLY_W'(DELAY_FIRST);
  localparam logic [DLY_W-1:0]   DL_LAST  = DLY_W'(DELAY_LAST);

  seq_state_e         state;
  logic [SHIFT_W-1:0] cur_shift;
  logic [DLY_W-1:0]   cur_delay;
  logic               w_go, w_ok, w_to;
  logic               t_go, t_done, t_pass;
  logic               clr_all, clr_run, res_valid;
  logic               any_pass;
  logic [SHIFT_W-1:0] best_shift;
  logic [DLY_W-1:0]   mid_delay;
  logic [DLY_W-1:0]   lane_val;

  assign clr_all   = (state == ST_IDLE) && start_i;
  assign clr_run   = (state == ST_EVAL) && (cur_delay == DL_LAST);
  assign res_valid = (state == ST_TEST) && t_done;

  dqs_status_waiter #(
    .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_wait (
    .clk(clk), .rst(rst), .go(w_go), .lock_i(lock_i), .init_i(init_done_i),
    .ok(w_ok), .timeout(w_to)
  );

  dqs_pattern_tester #(
    .ADDR_W(ADDR_W), .PAT_WORDS(PAT_WORDS), .READS(READS)
  ) u_test (
    .clk(clk), .rst(rst), .go(t_go), .mem_rdata(mem_rdata_i),
    .mem_we(mem_we_o), .mem_re(mem_re_o), .mem_addr(mem_addr_o),
    .mem_wdata(mem_wdata_o), .done(t_done), .pass(t_pass)
  );

  dqs_window_tracker #(
    .DLY_W(DLY_W), .SHIFT_W(SHIFT_W)
  ) u_track (
    .clk(clk), .rst(rst), .clr_all(clr_all), .clr_run(clr_run),
    .res_valid(res_valid), .res_pass(t_pass),
    .cur_shift(cur_shift), .cur_delay(cur_delay),
    .any_pass(any_pass), .best_shift(best_shift), .mid_delay(mid_delay)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_delay_o[g*DLY_W +: DLY_W] <= '0;
      end else if (state == ST_PROG || state == ST_FIN_PROG) begin
        lane_delay_o[g*DLY_W +: DLY_W] <= lane_val;
      end
    end
  end

  always_comb begin
    if (state == ST_PROG) lane_val = cur_delay;
    else if (any_pass)    lane_val = mid_delay;
    else                  lane_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_shift   <= SH_FIRST;
      cur_delay   <= DL_FIRST;
      core_run_o  <= 1'b0;
      wr_shift_o  <= SH_FIRST;
      out_shift_o <= SH_FIRST + SH_OFF;
      done_o      <= 1'b0;
      no_window_o <= 1'b0;
      err_o       <= 1'b0;
      err_shift_o <= '0;
      err_delay_o <= '0;
      w_go        <= 1'b0;
      t_go        <= 1'b0;
    end else begin
      w_go <= 1'b0;
      t_go <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state       <= ST_PROG;
          cur_shift   <= SH_FIRST;
          cur_delay   <= DL_FIRST;
          done_o      <= 1'b0;
          no_window_o <= 1'b0;
          err_o       <= 1'b0;
        end
        ST_PROG: begin
          core_run_o  <= 1'b0;
          wr_shift_o  <= cur_shift;
          out_shift_o <= cur_shift + SH_OFF;
          state       <= ST_ARM;
        end
        ST_ARM, ST_FIN_ARM: begin
          core_run_o <= 1'b1;
          w_go       <= 1'b1;
          state      <= (state == ST_ARM) ? ST_WAIT : ST_FIN_WAIT;
        end
        ST_WAIT: begin
          if (w_ok) begin
            t_go  <= 1'b1;
            state <= ST_TEST;
          end else if (w_to) begin
            err_o       <= 1'b1;
            err_shift_o <= cur_shift;
            err_delay_o <= cur_delay;
            core_run_o  <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_TEST: if (t_done) begin
          core_run_o <= 1'b0;
          state      <= ST_EVAL;
        end
        ST_EVAL: begin
          if (cur_delay != DL_LAST) begin
            cur_delay <= cur_delay + 1'b1;
            state     <= ST_PROG;
          end else if (cur_shift != SH_LAST) begin
            cur_delay <= DL_FIRST;
            cur_shift <= cur_shift + 1'b1;
            state     <= ST_PROG;
          end else begin
            state <= ST_FIN_PROG;
          end
        end
        ST_FIN_PROG: begin
          core_run_o  <= 1'b0;
          wr_shift_o  <= any_pass ? best_shift : SH_FIRST;
          out_shift_o <= (any_pass ? best_shift : SH_FIRST) + SH_OFF;
          state       <= ST_FIN_ARM;
        end
        ST_FIN_WAIT: begin
          if (w_ok) begin
            done_o      <= 1'b1;
            no_window_o <= !any_pass;
            state       <= ST_IDLE;
          end else if (w_to) begin
            err_o       <= 1'b1;
            err_shift_o <= wr_shift_o;
            err_delay_o <= lane_delay_o[DLY_W-1:0];
            core_run_o  <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_window_trainer_chk.sv
module dqs_window_trainer_chk #(
  parameter int LANES      = 9,
  parameter int DLY_W      = 7,
  parameter int SHIFT_W    = 8,
  parameter int OUT_OFFSET = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   init_done_i,
  input logic                   core_run_o,
  input logic [SHIFT_W-1:0]     wr_shift_o,
  input logic [SHIFT_W-1:0]     out_shift_o,
  input logic [LANES*DLY_W-1:0] lane_delay_o,
  input logic                   mem_we_o,
  input logic                   mem_re_o,
  input logic                   done_o,
  input logic                   no_window_o,
  input logic                   err_o
);
  AST_OUT_SHIFT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    out_shift_o == SHIFT_W'(wr_shift_o + SHIFT_W'(OUT_OFFSET)));  // R2
  AST_LANES_MATCH: assert property (@(posedge clk) disable iff (rst)
    lane_delay_o == {LANES{lane_delay_o[DLY_W-1:0]}});  // R3
  AST_CFG_STABLE_RUN: assert property (@(posedge clk) disable iff (rst)
    core_run_o && $past(core_run_o) |-> $stable(wr_shift_o) && $stable(lane_delay_o));  // R4
  AST_MEM_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o || mem_re_o) |-> (core_run_o && init_done_i));  // R6
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));  // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));  // R5
  AST_NOWIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    no_window_o |-> (done_o && lane_delay_o[DLY_W-1:0] == '0));  // R12
endmodule

bind dqs_window_trainer dqs_window_trainer_chk #(
  .LANES(LANES), .DLY_W(DLY_W), .SHIFT_W(SHIFT_W), .OUT_OFFSET(OUT_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .init_done_i(init_done_i), .core_run_o(core_run_o),
  .wr_shift_o(wr_shift_o), .out_shift_o(out_shift_o), .lane_delay_o(lane_delay_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .done_o(done_o),
  .no_window_o(no_window_o), .err_o(err_o)
);

// File: tb/dqs_window_trainer_tb.sv
module dqs_window_trainer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 9, DLY_W = 7, SHIFT_W = 8;
  localparam int SH_F = 64, SH_L = 66, DL_F = 1, DL_L = 12;
  localparam int PATN = 64, RD = 3, POLLS = 30, SETTLE = 8;
  localparam int LOCK_LAT = 3, INIT_LAT = 2;
  localparam int NSET = (SH_L - SH_F + 1) * (DL_L - DL_F + 1);

  logic clk = 0, rst = 1, start_i = 0, lock_i, init_done_i;
  logic core_run_o, mem_we_o, mem_re_o, done_o, no_window_o, err_o;
  logic [SHIFT_W-1:0] wr_shift_o, out_shift_o, err_shift_o;
  logic [LANES*DLY_W-1:0] lane_delay_o;
  logic [5:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic [DLY_W-1:0] err_delay_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_window_trainer #(
    .LANES(LANES), .DLY_W(DLY_W), .SHIFT_W(SHIFT_W), .SHIFT_FIRST(SH_F), .SHIFT_LAST(SH_L),
    .OUT_OFFSET(32), .DELAY_FIRST(DL_F), .DELAY_LAST(DL_L), .PAT_WORDS(PATN), .ADDR_W(6),
    .READS(RD), .POLL_LIMIT(POLLS), .SETTLE_CYCLES(SETTLE)
  ) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int scen = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Bench's own view of the training pattern (pair index within each 16-word group).
  function automatic logic [31:0] exp_pat(input int i);
    int p;
    logic b;
    logic [31:0] a0, a1;
    p = (i % 16) / 2;
    b = (p == 1) || (p == 3) || (p == 4) || (p == 6);
    case (i / 16)
      0: begin a0 = 32'h00000000; a1 = 32'hFFFFFFFF; end
      1: begin a0 = 32'hAAAAAAAA; a1 = 32'h55555555; end
      2: begin a0 = 32'hA5A5A5A5; a1 = 32'h5A5A5A5A; end
      default: begin a0 = 32'hAA55AA55; a1 = 32'h55AA55AA; end
    endcase
    return b ? a1 : a0;
  endfunction

  function automatic bit passes(input int sc, input int sh, input int d);
    case (sc)
      1: return (sh == 64 && d >= 3 && d <= 5) || (sh == 65 && (d == 2 || d == 3 || d >= 9)) ||
                (sh == 66 && d >= 1 && d <= 4);
      5: return (sh == 66 && d == 12);
      default: return 0;
    endcase
  endfunction

  // Memory core and delay-line model
  logic [31:0] mem [0:63];
  int cnt = 0, last_rd = 0;
  always @(posedge clk) begin
    if (!core_run_o) begin
      cnt <= 0; lock_i <= 0; init_done_i <= 0; last_rd <= 0;
    end else begin
      cnt <= cnt + 1;
      lock_i <= (cnt >= LOCK_LAT) && (scen != 3);
      init_done_i <= (cnt >= LOCK_LAT + INIT_LAT) && lock_i &&
                     !(scen == 4 && wr_shift_o == 65 && lane_delay_o[DLY_W-1:0] == 5);
    end
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) begin
      mem_rdata_i <= mem[mem_addr_o];
      if (mem_addr_o == 6'(PATN - 1)) begin
        last_rd <= last_rd + 1;
        if (last_rd == RD - 1 && !passes(scen, int'(wr_shift_o), int'(lane_delay_o[DLY_W-1:0])))
          mem_rdata_i <= mem[mem_addr_o] ^ 32'h0000_0100;
      end
    end
  end

  // Statistics monitor
  int wr_cnt, rd_cnt, pat_err, cfg_err, gap, gap_min, gap_max, to_cyc, to_meas;
  bit gap_arm, prev_run, prev_init, prev_err;
  logic [SHIFT_W-1:0] prev_ws;
  logic [LANES*DLY_W-1:0] prev_ld;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we_o) begin
        wr_cnt++;
        if (mem_wdata_o != exp_pat(int'(mem_addr_o))) pat_err++;
      end
      if (mem_re_o) rd_cnt++;
      if (core_run_o && prev_run && (wr_shift_o != prev_ws || lane_delay_o != prev_ld)) cfg_err++;
      if (init_done_i && !prev_init) begin gap = 0; gap_arm = 1; end
      else if (gap_arm) gap++;
      if (gap_arm && mem_we_o) begin
        gap_arm = 0;
        if (gap < gap_min) gap_min = gap;
        if (gap > gap_max) gap_max = gap;
      end
      if (core_run_o && !prev_run) to_cyc = 0; else to_cyc++;
      if (err_o && !prev_err) to_meas = to_cyc;
    end
    prev_run = core_run_o; prev_init = init_done_i; prev_err = err_o;
    prev_ws = wr_shift_o; prev_ld = lane_delay_o;
  end

  task automatic clear_stats();
    wr_cnt = 0; rd_cnt = 0; pat_err = 0; cfg_err = 0;
    gap_min = 1 << 30; gap_max = 0; gap_arm = 0; to_meas = -1;
  endtask

  typedef struct {
    string tag; bit err; bit nowin; int shift; int dly;
  } exp_t;
  exp_t sb[$];

  // Scoreboard monitor: compares each completion against the queued expectation
  initial begin
    bit pd = 0, pe = 0;
    forever begin
      @(negedge clk);
      if ((done_o && !pd) || (err_o && !pe)) begin
        exp_t e;
        if (sb.size() == 0) begin
          check(0, "R1 unexpected completion", 1, 0);
        end else begin
          e = sb.pop_front();
          check(err_o == e.err, {e.tag, " err flag"}, err_o, e.err);
          check(done_o == !e.err, {e.tag, " done flag"}, done_o, !e.err);
          if (e.err) begin
            check(err_shift_o == e.shift, {e.tag, " err shift"}, err_shift_o, e.shift);
            check(err_delay_o == e.dly, {e.tag, " err delay"}, err_delay_o, e.dly);
            check(!core_run_o, {e.tag, " core stopped"}, core_run_o, 0);
          end else begin
            check(no_window_o == e.nowin, {e.tag, " no-window flag"}, no_window_o, e.nowin);
            check(wr_shift_o == e.shift, {e.tag, " final shift"}, wr_shift_o, e.shift);
            check(out_shift_o == e.shift + 32, "R2 out shift offset", out_shift_o, e.shift + 32);
            check(lane_delay_o[DLY_W-1:0] == e.dly, {e.tag, " final delay"},
                  lane_delay_o[DLY_W-1:0], e.dly);
            check(lane_delay_o == {LANES{7'(e.dly)}}, "R3 all lanes equal", lane_delay_o[13:7], e.dly);
            check(core_run_o, "R11 core left running", core_run_o, 1);
          end
        end
      end
      pd = done_o; pe = err_o;
    end
  end

  task automatic run_case(input int sc, input exp_t e, input bit poke);
    scen = sc;
    clear_stats();
    sb.push_back(e);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (2) @(negedge clk);
    check(!done_o && !err_o, "R1 start clears flags", done_o | err_o, 0);
    if (poke) begin
      repeat (500) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!done_o && !err_o && !no_window_o && !core_run_o && !mem_we_o && !mem_re_o,
          "R1 reset flags", {done_o, err_o, no_window_o, core_run_o}, 0);
    check(wr_shift_o == SH_F && lane_delay_o == '0, "R1 reset config", wr_shift_o, SH_F);

    // R9 R10 R11: tie between shift 65 and 66 windows, no carry across shifts
    e = '{"R10 tie window", 0, 0, 66, 2};
    run_case(1, e, 1);
    check(wr_cnt == NSET * PATN, "R7 write count", wr_cnt, NSET * PATN);
    check(rd_cnt == NSET * PATN * RD, "R8 read count", rd_cnt, NSET * PATN * RD);
    check(pat_err == 0, "R7 pattern contents", pat_err, 0);
    check(cfg_err == 0, "R4 config held while core runs", cfg_err, 0);
    check(gap_min >= SETTLE && gap_max <= SETTLE + 6, "R6 settle gap", gap_min, SETTLE);

    // R12: nothing passes
    e = '{"R12 no window", 0, 1, SH_F, 0};
    run_case(2, e, 0);
    check(rd_cnt == NSET * PATN * RD, "R8 full sweep on all-fail", rd_cnt, NSET * PATN * RD);

    // R3 R10: lone pass at last grid point
    e = '{"R3 last point window", 0, 0, 66, 12};
    run_case(5, e, 0);

    // R5: lock never arrives
    e = '{"R5 lock timeout", 1, 0, SH_F, DL_F};
    run_case(3, e, 0);
    check(to_meas >= POLLS && to_meas <= POLLS + 5, "R5 timeout poll count", to_meas, POLLS);
    check(wr_cnt == 0, "R5 no memory test after timeout", wr_cnt, 0);

    // R4 R5: init never completes at shift 65 delay 5
    e = '{"R4 init timeout", 1, 0, 65, 5};
    run_case(4, e, 0);
    check(wr_cnt == (DL_L + 4) * PATN, "R9 settings tested before stall", wr_cnt, (DL_L + 4) * PATN);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule